// File: doc/BRIEF.md
# POST Code Capture with Timestamps

This block records the progress codes a host writes to the two debug I/O ports at 80h and 81h. Each accepted write stores one byte in a small FIFO. Beside the byte, the FIFO stores the value a free-running timestamp counter held when the write was sampled. Firmware can therefore recover both the sequence of boot codes and the spacing between them. A bus protocol front end, outside this block, presents each host write as a single-cycle strobe with an address, 16 data bits and two byte enables.

Firmware reads the oldest entry through a capture word. The code byte sits in the low bits and the timestamp sits above it. Firmware pulses a read strobe to remove that entry, and polls a not-empty flag to learn whether more entries remain. An interrupt line is raised while the number of stored entries is strictly greater than a programmable level. A write that arrives while the FIFO is full is dropped and sets a sticky overrun flag, which only an explicit clear pulse resets.

Top module: `post_capture`

## Requirements
- R1: A strobe with `wr_en`=1 stores one entry only when `wr_addr` is 0080h or 0081h and `wr_be[0]`=1. Any other address, or `wr_be[0]`=0, stores nothing.
- R2: A 16-bit write (`wr_be`=2'b11) to either port stores exactly one entry, which holds only `wr_data[7:0]`. The upper byte is dropped.
- R3: While the FIFO is not empty, `cap_word[7:0]` carries the oldest stored byte and `cap_word[DATA_W+TS_W-1:8]` carries its timestamp.
- R4: The timestamp counter is TS_W bits wide and starts at 0 at reset. It advances by one every PRESCALE clock cycles and wraps modulo 2^TS_W. An entry stores the counter value present at the clock edge that samples its write, which is floor((k-1)/PRESCALE) mod 2^TS_W for the k-th edge after reset release.
- R5: A pulse on `rd_pop` removes one entry. Entries leave in the order they were written.
- R6: While the FIFO is empty, `cap_word` reads 0. A `rd_pop` pulse while empty changes nothing, so the next write is stored and read back normally.
- R7: `not_empty` is 1 exactly while at least one entry is stored. It changes on the clock edge after the push or pop.
- R8: `irq` is 1 exactly while the stored entry count is strictly greater than `irq_level`.
- R9: The FIFO holds DEPTH entries (16 by default). A qualifying write that arrives while the FIFO is full is discarded and sets `overrun`. The flag stays set until a pulse on `ovr_clr`. If a new discard and a clear happen in the same cycle, the flag stays set.
- R10: After reset, `not_empty`, `irq` and `overrun` are 0 and `cap_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host I/O write strobe, one cycle per transaction |
| wr_addr | input | 16 | Host I/O address |
| wr_data | input | 16 | Write data, with the byte for `wr_addr` in bits [7:0] |
| wr_be | input | 2 | Byte enables for the two data lanes |
| rd_pop | input | 1 | Removes the oldest entry |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| irq_level | input | $clog2(DEPTH)+1 | Interrupt level; `irq` is raised while the count is above it |
| cap_word | output | DATA_W+TS_W | Oldest entry as {timestamp, byte}, or 0 when empty |
| not_empty | output | 1 | At least one entry is stored |
| irq | output | 1 | The stored count is greater than `irq_level` |
| overrun | output | 1 | Sticky flag: a write was dropped while the FIFO was full |

## Verification
The bench targets several corner cases:
- **Address and lane decode:** it writes next to the two ports and with the low lane disabled. A loose decode would store entries that should have been ignored.
- **Word writes:** a design that stored the upper byte, or split the word into two entries, would misalign every later readback.
- **Full FIFO:** it fills to exactly DEPTH and then offers one more write. A design that wrapped its write pointer would overwrite the oldest code instead of dropping the new one and flagging overrun.
- **Interrupt threshold:** it steps the count across `irq_level` to catch a greater-or-equal comparison.
- **Empty pops:** it pops while empty to catch a count that underflows.
- **Timestamp timing:** it checks the stored timestamps, including after a wrap. This catches a counter sampled one edge late or one that saturates.

// File: rtl/post_capture_pkg.sv
package post_capture_pkg;

    localparam int unsigned IO_ADDR_W = 16;
    localparam logic [IO_ADDR_W-1:0] POST_PORT_LO = 16'h0080;
    localparam logic [IO_ADDR_W-1:0] POST_PORT_HI = 16'h0081;

    function automatic logic port_hit(input logic [IO_ADDR_W-1:0] addr);
        return (addr == POST_PORT_LO) || (addr == POST_PORT_HI);
    endfunction

endpackage

// File: rtl/post_ts_counter.sv
module post_ts_counter #(
    parameter int unsigned TS_W     = 24,
    parameter int unsigned PRESCALE = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts
);
    localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [TS_W-1:0]  ts;
    } ts_state_t;

    ts_state_t st_d, st_q;
    logic      tick;

    always_comb begin
        st_d = st_q;
        tick = (st_q.pre == PRE_LAST);
        if (tick) begin
            st_d.pre = '0;
            st_d.ts  = st_q.ts + 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ts = st_q.ts;

    // R4: the count holds between ticks and steps by one (wrapping) on a tick
    a_r4_ts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ts));
    a_r4_ts_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ts == TS_W'($past(ts) + 1'b1));

endmodule

// File: rtl/post_fifo.sv
module post_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic                       ovr_clr,
    input  logic [W-1:0]               push_data,
    output logic [W-1:0]               head_data,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       overrun
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = PTR_W + 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             ovr;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic        full, empty, do_push, do_pop;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        st_d    = st_q;
        full    = (st_q.cnt == CNT_FULL);
        empty   = (st_q.cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) st_d.wr = (st_q.wr == PTR_LAST) ? '0 : st_q.wr + 1'b1;
        if (do_pop)  st_d.rd = (st_q.rd == PTR_LAST) ? '0 : st_q.rd + 1'b1;
        unique case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (push && full) st_d.ovr = 1'b1;
        else if (ovr_clr) st_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= push_data;
    end

    assign head_data = mem_q[st_q.rd];
    assign count     = st_q.cnt;
    assign overrun   = st_q.ovr;

    // R9: occupancy never goes past the depth
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_FULL);
    // R9: the overrun flag only drops through a clear
    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !ovr_clr |=> overrun);
    // R9: a write into a full FIFO leaves the occupancy at the depth
    a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop && count == CNT_FULL |=> count == CNT_FULL && overrun);
    // R6: a pop on an empty FIFO does not underflow
    a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !push && count == '0 |=> count == '0);
    // R5: a lone pop removes exactly one entry
    a_r5_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !push && count != '0 |=> count == $past(count) - 1'b1);

endmodule

// File: rtl/post_capture.sv
module post_capture #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned TS_W     = 24,
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned PRESCALE = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [15:0]                wr_addr,
    input  logic [15:0]                wr_data,
    input  logic [1:0]                 wr_be,
    input  logic                       rd_pop,
    input  logic                       ovr_clr,
    input  logic [$clog2(DEPTH):0]     irq_level,
    output logic [DATA_W+TS_W-1:0]     cap_word,
    output logic                       not_empty,
    output logic                       irq,
    output logic                       overrun
);
    import post_capture_pkg::*;

    localparam int unsigned ENTRY_W = DATA_W + TS_W;
    localparam int unsigned CNT_W   = $clog2(DEPTH) + 1;

    logic [TS_W-1:0]    ts_now;
    logic [ENTRY_W-1:0] head;
    logic [CNT_W-1:0]   count;
    logic               hit_d;
    logic [ENTRY_W-1:0] entry_d;

    post_ts_counter #(.TS_W(TS_W), .PRESCALE(PRESCALE)) u_ts (
        .clk   (clk),
        .rst_n (rst_n),
        .ts    (ts_now)
    );

    always_comb begin
        hit_d   = wr_en && wr_be[0] && port_hit(wr_addr);
        entry_d = {ts_now, wr_data[DATA_W-1:0]};
    end

    post_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (hit_d),
        .pop       (rd_pop),
        .ovr_clr   (ovr_clr),
        .push_data (entry_d),
        .head_data (head),
        .count     (count),
        .overrun   (overrun)
    );

    assign not_empty = (count != '0);
    assign cap_word  = not_empty ? head : '0;
    assign irq       = (count > irq_level);

    // R6: nothing leaks onto the capture word while empty
    a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !not_empty |-> cap_word == '0);
    // R1: a strobe outside the two ports never raises the occupancy flag
    a_r1_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        !not_empty && !(wr_en && wr_be[0] && port_hit(wr_addr)) |=> !not_empty);
    // R7: an accepted write always leaves something to read
    a_r7_push_visible: assert property (@(posedge clk) disable iff (!rst_n)
        hit_d && !rd_pop |=> not_empty);

endmodule

// File: tb/post_capture_bench.sv
module post_capture_bench;
    localparam int DATA_W = 8;
    localparam int TS_W   = 10;
    localparam int DEPTH  = 16;
    localparam int PRE    = 3;
    localparam int EW     = DATA_W + TS_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_pop = 1'b0, ovr_clr = 1'b0;
    logic [15:0] wr_addr = '0, wr_data = '0;
    logic [1:0]  wr_be = '0;
    logic [4:0]  irq_level = 5'd2;
    logic [EW-1:0] cap_word;
    logic not_empty, irq, overrun;

    always #2 clk = ~clk;

    post_capture #(.DATA_W(DATA_W), .TS_W(TS_W), .DEPTH(DEPTH), .PRESCALE(PRE)) u_post_capture (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_be(wr_be), .rd_pop(rd_pop), .ovr_clr(ovr_clr), .irq_level(irq_level),
        .cap_word(cap_word), .not_empty(not_empty), .irq(irq), .overrun(overrun));

    int cyc;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    int checks = 0, errors = 0;
    logic [EW-1:0] mq [0:63];
    int m_head = 0, m_cnt = 0;

    // {addr, data, be, expect_store, expect_byte}
    localparam logic [42:0] VEC [0:7] = '{
        {16'h0080, 16'h0012, 2'b01, 1'b1, 8'h12},
        {16'h0081, 16'h0034, 2'b01, 1'b1, 8'h34},
        {16'h0082, 16'h0056, 2'b01, 1'b0, 8'h00},
        {16'h007F, 16'h0078, 2'b01, 1'b0, 8'h00},
        {16'h0080, 16'hBEEF, 2'b11, 1'b1, 8'hEF},
        {16'h0080, 16'h0099, 2'b00, 1'b0, 8'h00},
        {16'h0081, 16'h00AA, 2'b10, 1'b0, 8'h00},
        {16'h0081, 16'hC35A, 2'b11, 1'b1, 8'h5A}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be,
                            input logic store, input logic [7:0] byte_exp);
        @(negedge clk);
        if (store && m_cnt < DEPTH) begin
            mq[(m_head + m_cnt) % 64] = {TS_W'((cyc / PRE) % (1 << TS_W)), byte_exp};
            m_cnt++;
        end
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input string tag);
        @(negedge clk);
        if (m_cnt > 0) chk(tag, 32'(cap_word), 32'(mq[m_head]));
        else           chk(tag, 32'(cap_word), 32'd0);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        if (m_cnt > 0) begin m_head = (m_head + 1) % 64; m_cnt--; end
    endtask

    task automatic chk_flags(input string tag);
        chk({tag, " not_empty R7"}, 32'(not_empty), 32'(m_cnt > 0));
        chk({tag, " irq R8"}, 32'(irq), 32'(m_cnt > int'(irq_level)));
    endtask

    logic done = 1'b0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 not_empty", 32'(not_empty), 0);
        chk("R10 irq", 32'(irq), 0);
        chk("R10 overrun", 32'(overrun), 0);
        chk("R10 cap_word", 32'(cap_word), 0);
        rst_n = 1'b1;

        // R1 R2: decode and lane table, flags after each strobe
        for (int i = 0; i < 8; i++) begin
            do_write(VEC[i][42:27], VEC[i][26:11], VEC[i][10:9], VEC[i][8], VEC[i][7:0]);
            chk_flags("R1 R2 table");
        end
        chk("R1 R2 stored count", 32'(m_cnt), 32'd4);
        // R3 R4 R5: drain in order
        for (int i = 0; i < 4; i++) do_read("R3 R4 R5 drain");
        chk_flags("R5 after drain");

        // R6: pop while empty, then a normal write/read
        do_read("R6 empty read");
        do_read("R6 empty read again");
        chk_flags("R6 after empty pops");
        do_write(16'h0080, 16'h00C1, 2'b01, 1'b1, 8'hC1);
        chk_flags("R6 after refill");
        do_read("R6 readback after empty pops");

        // R8 R9: fill to depth with level 15, then one more
        irq_level = 5'd15;
        for (int i = 0; i < DEPTH; i++) begin
            do_write(16'h0081, 16'(8'h40 + i), 2'b01, 1'b1, 8'(8'h40 + i));
            chk_flags("R8 fill");
        end
        chk("R9 no overrun at depth", 32'(overrun), 0);
        do_write(16'h0080, 16'h00EE, 2'b01, 1'b1, 8'hEE);
        @(negedge clk);
        chk("R9 overrun set", 32'(overrun), 1);
        for (int i = 0; i < DEPTH; i++) do_read("R9 R5 drain full");
        chk_flags("R9 empty after drain");
        chk("R9 overrun sticky", 32'(overrun), 1);
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        chk("R9 overrun cleared", 32'(overrun), 0);

        // R4: timestamp wrap after 2^TS_W ticks
        irq_level = 5'd0;
        repeat (PRE * (1 << TS_W) + 5) @(negedge clk);
        do_write(16'h0080, 16'h0077, 2'b01, 1'b1, 8'h77);
        chk_flags("R8 level zero");
        do_read("R4 wrapped timestamp");
        do_write(16'h0081, 16'h0066, 2'b01, 1'b1, 8'h66);
        do_read("R4 second stamp");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule